// File: doc/BRIEF.md
# Bus Timeout Error Logger

This block sits beside a shared-bus arbiter and records every transaction that timed out because no slave answered. The arbiter presents a one-cycle timeout event. The event carries the index of the master that issued the transaction, together with the transaction's address, byte enables, size, type, direction and a lock request. For each master the logger keeps four status bits: an error flag, an ownership flag for the shared address record, a direction bit and a lock bit. The address record itself is held once for the whole bus.

Software reaches the logger through a small register port of eight word registers. The port has an address, read and write strobes, write data, read data and an acknowledge. Software polls or clears the error flags and inspects the captured record. A control register gates an edge-type interrupt. The same register offers a self-clearing soft reset and a test mode in which the record fields can be loaded by hand. A master that asks for a lock freezes the record until software clears that master's error flag.

Top module: `berr_logger`

## Requirements
- R1: After reset every status register and every record field reads 0, the control register reads 1 (interrupt enable set), and `irq` sits at its inactive level.
- R2: A timeout event from master m sets bit m of the error register (offset 0), makes the owner register (offset 1) equal to the one-hot value of m, sets bit m of the direction register (offset 2) to 1 for a read and 0 for a write, sets bit m of the lock register (offset 3) to the event's lock request, and captures address (offset 4), byte enables (offset 5, in the low data-width/8 bits) and size/type (offset 6, size in bits 3:0, type in bits 6:4). At most one owner bit is ever set.
- R3: Writing the error register clears, for each data bit that is 1, that master's error, owner, direction and lock bits. Bits written as 0 are left unchanged.
- R4: While the owning master's lock bit is set, later timeouts change neither the record nor the owner. A locked master's own direction bit is also kept. Other unlocked masters still set their own error and direction bits.
- R5: Once a locked owner's error bit has been cleared, the next timeout overwrites the record and takes ownership.
- R6: Writes to the owner, direction and lock registers have no effect.
- R7: The record fields at offsets 4 to 6 accept writes only while control bit 2 (test enable) is 1. Bits beyond a field's width read as 0.
- R8: Control bit 0 is interrupt enable and reads back as written. Bit 1 always reads 0. Writing bit 1 as 1 returns every register, control included, to its reset value.
- R9: One cycle after a timeout event with interrupt enable set, `irq` is at its active level (parameter `IRQ_ACT_HIGH`) for exactly one cycle, whatever the lock state. With interrupt enable clear, no pulse is produced.
- R10: An access whose address falls in the eight-word window at `BASE` (low three address bits zero) is acknowledged exactly one cycle later, with read data valid alongside. An access outside the window gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW | Register word address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| reg_rdata | output | DW | Read data, valid with acknowledge |
| to_valid | input | 1 | Timeout event strobe |
| to_master | input | MIDX_W | Index of the timed-out master |
| to_addr | input | 32 | Address of the timed-out transaction |
| to_be | input | DATA_W/8 | Byte enables of the transaction |
| to_size | input | 4 | Size code of the transaction |
| to_type | input | 3 | Type code of the transaction |
| to_rnw | input | 1 | 1 for a read, 0 for a write |
| to_lock | input | 1 | Lock request for this transaction |
| irq | output | 1 | Edge-type error interrupt |

## Verification
A timeout event and a register write both update state on the edge that samples them. A register read therefore sees the new state when it is issued in the following cycle, and its acknowledge and data appear one cycle after that. The interrupt pulse belongs to the cycle right after the event's edge, and it is gone one cycle later. The bench drives all strobes on falling edges. It samples `irq` on the first and second falling edges after an event, and it reads `reg_ack`/`reg_rdata` on the falling edge that follows each strobe, so every sample lands in the cycle where the result is due.

// File: rtl/berr_pkg.sv
package berr_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 4;
    localparam int TYPE_W = 3;

    typedef enum logic [2:0] {
        OFF_DET = 3'd0,
        OFF_OWN = 3'd1,
        OFF_RNW = 3'd2,
        OFF_LCK = 3'd3,
        OFF_ADR = 3'd4,
        OFF_BE  = 3'd5,
        OFF_SZT = 3'd6,
        OFF_CTL = 3'd7
    } reg_off_e;

    localparam int CTL_IE   = 0;
    localparam int CTL_SRST = 1;
    localparam int CTL_TEST = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [TYPE_W-1:0] kind;
    } rec_t;

    function automatic logic [31:0] pack_szt(input logic [SIZE_W-1:0] size,
                                             input logic [TYPE_W-1:0] kind);
        return {25'd0, kind, size};
    endfunction
endpackage

// File: rtl/berr_status.sv
module berr_status #(
    parameter int NM     = 4,
    parameter int MIDX_W = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              to_valid,
    input  logic [MIDX_W-1:0] to_master,
    input  logic              to_rnw,
    input  logic              to_lock,
    input  logic [NM-1:0]     w1c,
    output logic [NM-1:0]     det,
    output logic [NM-1:0]     own,
    output logic [NM-1:0]     rnw,
    output logic [NM-1:0]     lck,
    output logic              rec_capture
);
    logic rec_locked;
    assign rec_locked  = |(own & lck);
    assign rec_capture = to_valid && !rec_locked;

    for (genvar i = 0; i < NM; i++) begin : g_mst
        logic hit;
        assign hit = to_valid && (to_master == MIDX_W'(i));
        always_ff @(posedge clk) begin
            if (clr) begin
                det[i] <= 1'b0;
                own[i] <= 1'b0;
                rnw[i] <= 1'b0;
                lck[i] <= 1'b0;
            end else if (w1c[i]) begin
                det[i] <= 1'b0;
                own[i] <= 1'b0;
                rnw[i] <= 1'b0;
                lck[i] <= 1'b0;
            end else begin
                if (hit && !lck[i]) begin
                    det[i] <= 1'b1;
                    rnw[i] <= to_rnw;
                    lck[i] <= to_lock;
                end
                if (rec_capture) own[i] <= hit;
            end
        end
    end
endmodule

// File: rtl/berr_record.sv
module berr_record
    import berr_pkg::*;
#(
    parameter int BE_W = 8
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            capture,
    input  rec_t            cap_rec,
    input  logic [BE_W-1:0] cap_be,
    input  logic            we_addr,
    input  logic            we_be,
    input  logic            we_szt,
    input  logic [31:0]     wdata,
    output rec_t            rec,
    output logic [BE_W-1:0] be
);
    always_ff @(posedge clk) begin
        if (clr) begin
            rec <= '0;
            be  <= '0;
        end else if (capture) begin
            rec <= cap_rec;
            be  <= cap_be;
        end else begin
            if (we_addr) rec.addr <= wdata[ADDR_W-1:0];
            if (we_be)   be       <= wdata[BE_W-1:0];
            if (we_szt) begin
                rec.size <= wdata[SIZE_W-1:0];
                rec.kind <= wdata[SIZE_W+TYPE_W-1:SIZE_W];
            end
        end
    end
endmodule

// File: rtl/berr_regif.sv
module berr_regif
    import berr_pkg::*;
#(
    parameter int           NM   = 4,
    parameter int           AW   = 10,
    parameter int           DW   = 32,
    parameter int           BE_W = 8,
    parameter logic [AW-1:0] BASE = 10'h040
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic            reg_ack,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NM-1:0]   det,
    input  logic [NM-1:0]   own,
    input  logic [NM-1:0]   rnw,
    input  logic [NM-1:0]   lck,
    input  rec_t            rec,
    input  logic [BE_W-1:0] be,
    output logic            ie,
    output logic            srst,
    output logic [NM-1:0]   w1c,
    output logic            we_addr,
    output logic            we_be,
    output logic            we_szt
);
    logic     hit, wr_en, test_q, clr;
    reg_off_e off;
    logic [DW-1:0] mux;

    assign hit   = (reg_addr[AW-1:3] == BASE[AW-1:3]);
    assign off   = reg_off_e'(reg_addr[2:0]);
    assign wr_en = reg_wr && hit;
    assign srst  = wr_en && (off == OFF_CTL) && reg_wdata[CTL_SRST];
    assign clr   = rst || srst;
    assign w1c   = (wr_en && off == OFF_DET) ? reg_wdata[NM-1:0] : '0;
    assign we_addr = wr_en && test_q && (off == OFF_ADR);
    assign we_be   = wr_en && test_q && (off == OFF_BE);
    assign we_szt  = wr_en && test_q && (off == OFF_SZT);

    always_ff @(posedge clk) begin
        if (clr) begin
            ie     <= 1'b1;
            test_q <= 1'b0;
        end else if (wr_en && off == OFF_CTL) begin
            ie     <= reg_wdata[CTL_IE];
            test_q <= reg_wdata[CTL_TEST];
        end
    end

    always_comb begin
        case (off)
            OFF_DET: mux = DW'(det);
            OFF_OWN: mux = DW'(own);
            OFF_RNW: mux = DW'(rnw);
            OFF_LCK: mux = DW'(lck);
            OFF_ADR: mux = DW'(rec.addr);
            OFF_BE:  mux = DW'(be);
            OFF_SZT: mux = DW'(pack_szt(rec.size, rec.kind));
            default: mux = DW'({test_q, 1'b0, ie});
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack   <= (reg_rd || reg_wr) && hit;
            reg_rdata <= (reg_rd && hit) ? mux : '0;
        end
    end
endmodule

// File: rtl/berr_logger.sv
module berr_logger
    import berr_pkg::*;
#(
    parameter int            NM           = 4,
    parameter int            DATA_W       = 64,
    parameter int            AW           = 10,
    parameter int            DW           = 32,
    parameter logic [AW-1:0] BASE         = 10'h040,
    parameter bit            IRQ_ACT_HIGH = 1'b1,
    localparam int           MIDX_W       = (NM > 1) ? $clog2(NM) : 1,
    localparam int           BE_W         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_ack,
    output logic [DW-1:0]     reg_rdata,
    input  logic              to_valid,
    input  logic [MIDX_W-1:0] to_master,
    input  logic [31:0]       to_addr,
    input  logic [BE_W-1:0]   to_be,
    input  logic [3:0]        to_size,
    input  logic [2:0]        to_type,
    input  logic              to_rnw,
    input  logic              to_lock,
    output logic              irq
);
    logic [NM-1:0]   det, own, rnw, lck, w1c;
    logic            ie, srst, clr, rec_capture, we_addr, we_be, we_szt, irq_q;
    rec_t            rec, cap_rec;
    logic [BE_W-1:0] be;

    assign clr     = rst || srst;
    assign cap_rec = '{addr: to_addr, size: to_size, kind: to_type};

    berr_status #(.NM(NM), .MIDX_W(MIDX_W)) u_status (
        .clk(clk), .clr(clr), .to_valid(to_valid), .to_master(to_master),
        .to_rnw(to_rnw), .to_lock(to_lock), .w1c(w1c),
        .det(det), .own(own), .rnw(rnw), .lck(lck), .rec_capture(rec_capture)
    );

    berr_record #(.BE_W(BE_W)) u_record (
        .clk(clk), .clr(clr), .capture(rec_capture), .cap_rec(cap_rec), .cap_be(to_be),
        .we_addr(we_addr), .we_be(we_be), .we_szt(we_szt), .wdata(reg_wdata[31:0]),
        .rec(rec), .be(be)
    );

    berr_regif #(.NM(NM), .AW(AW), .DW(DW), .BE_W(BE_W), .BASE(BASE)) u_regif (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .det(det), .own(own), .rnw(rnw), .lck(lck), .rec(rec), .be(be),
        .ie(ie), .srst(srst), .w1c(w1c), .we_addr(we_addr), .we_be(we_be), .we_szt(we_szt)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= to_valid && ie;
    end

    assign irq = IRQ_ACT_HIGH ? irq_q : !irq_q;
endmodule

// File: rtl/berr_logger_chk.sv
module berr_logger_chk #(
    parameter int            NM           = 4,
    parameter int            AW           = 10,
    parameter logic [AW-1:0] BASE         = 10'h040,
    parameter bit            IRQ_ACT_HIGH = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] reg_addr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic          reg_ack,
    input logic          to_valid,
    input logic          irq,
    input logic          ie,
    input logic          srst,
    input logic [NM-1:0] own,
    input logic [NM-1:0] lck,
    input logic [31:0]   rec_addr
);
    logic in_win;
    assign in_win = (reg_rd || reg_wr) && (reg_addr[AW-1:3] == BASE[AW-1:3]);

    // R10
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst) in_win |=> reg_ack);
    // R10
    ack_only_chk: assert property (@(posedge clk) disable iff (rst) !in_win |=> !reg_ack);
    // R2
    owner_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(own));
    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        to_valid && ie |=> (irq == IRQ_ACT_HIGH));
    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !to_valid |=> (irq != IRQ_ACT_HIGH));
    // R4
    rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        to_valid && (|(own & lck)) && !reg_wr |=> $stable(rec_addr) && $stable(own));
    // R8
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> (own == '0) && (lck == '0) && ie);
endmodule

bind berr_logger berr_logger_chk #(
    .NM(NM), .AW(AW), .BASE(BASE), .IRQ_ACT_HIGH(IRQ_ACT_HIGH)
) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_ack(reg_ack), .to_valid(to_valid), .irq(irq), .ie(ie), .srst(srst),
    .own(own), .lck(lck), .rec_addr(rec.addr)
);

// File: tb/berr_logger_test.sv
`timescale 1ns/1ps
module berr_logger_test;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam logic [AW-1:0] BASE = 10'h040;

    logic clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic reg_ack;
    logic to_valid = 1'b0, to_rnw = 1'b0, to_lock = 1'b0;
    logic [1:0] to_master = '0;
    logic [31:0] to_addr = '0;
    logic [7:0] to_be = '0;
    logic [3:0] to_size = '0;
    logic [2:0] to_type = '0;
    logic irq;

    int checks = 0, failures = 0;
    logic [31:0] rd_v;

    always #5 clk = ~clk;

    berr_logger #(.NM(4), .DATA_W(64), .AW(AW), .DW(DW), .BASE(BASE), .IRQ_ACT_HIGH(1'b1)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .to_valid(to_valid), .to_master(to_master), .to_addr(to_addr), .to_be(to_be),
        .to_size(to_size), .to_type(to_type), .to_rnw(to_rnw), .to_lock(to_lock), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [31:0] a;
        logic [7:0]  b;
        logic [3:0]  s;
        logic [2:0]  t;
        logic        r;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{m: 2'd0, a: 32'h1000_0004, b: 8'hFF, s: 4'h0, t: 3'd0, r: 1'b1},
        '{m: 2'd3, a: 32'hFFFF_FFFC, b: 8'h01, s: 4'hF, t: 3'd7, r: 1'b0},
        '{m: 2'd2, a: 32'h0000_0000, b: 8'hA5, s: 4'h9, t: 3'd5, r: 1'b1},
        '{m: 2'd1, a: 32'h8765_4320, b: 8'h80, s: 4'h3, t: 3'd2, r: 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rreg(input logic [2:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = BASE | AW'(off);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R10 read ack", {31'd0, reg_ack}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic wreg(input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_addr = BASE | AW'(off);
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R10 write ack", {31'd0, reg_ack}, 32'd1);
    endtask

    task automatic rchk(input string tag, input logic [2:0] off, input logic [31:0] exp);
        logic [31:0] d;
        rreg(off, d);
        chk(tag, d, exp);
    endtask

    task automatic tout(input logic [1:0] m, input logic [31:0] a, input logic [7:0] b,
                        input logic [3:0] s, input logic [2:0] t, input logic r,
                        input logic lk, input logic exp_irq);
        @(negedge clk);
        to_valid = 1'b1; to_master = m; to_addr = a; to_be = b;
        to_size = s; to_type = t; to_rnw = r; to_lock = lk;
        @(negedge clk);
        to_valid = 1'b0;
        chk("R9 irq pulse", {31'd0, irq}, {31'd0, exp_irq});
        @(negedge clk);
        chk("R9 irq one cycle", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq idle", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 7; k++) rchk("R1 reg zero", 3'(k), 32'd0);
        rchk("R1 ctrl default", 3'd7, 32'd1);

        // R2 table of single events, each cleared afterwards (R3)
        for (int k = 0; k < 4; k++) begin
            tout(TBL[k].m, TBL[k].a, TBL[k].b, TBL[k].s, TBL[k].t, TBL[k].r, 1'b0, 1'b1);
            rchk("R2 detect", 3'd0, 32'd1 << TBL[k].m);
            rchk("R2 owner", 3'd1, 32'd1 << TBL[k].m);
            rchk("R2 rnw", 3'd2, {31'd0, TBL[k].r} << TBL[k].m);
            rchk("R2 lock", 3'd3, 32'd0);
            rchk("R2 addr", 3'd4, TBL[k].a);
            rchk("R2 be", 3'd5, {24'd0, TBL[k].b});
            rchk("R2 size type", 3'd6, {25'd0, TBL[k].t, TBL[k].s});
            wreg(3'd0, 32'd1 << TBL[k].m);
            rchk("R3 cleared", 3'd0, 32'd0);
            rchk("R3 owner cleared", 3'd1, 32'd0);
        end

        // R4 lock holds the record
        tout(2'd1, 32'hAAAA_0001, 8'h0F, 4'h2, 3'd1, 1'b1, 1'b1, 1'b1);
        rchk("R2 lock set", 3'd3, 32'h2);
        tout(2'd2, 32'hBBBB_0002, 8'hF0, 4'h3, 3'd2, 1'b1, 1'b0, 1'b1);
        rchk("R4 other detect", 3'd0, 32'h6);
        rchk("R4 owner kept", 3'd1, 32'h2);
        rchk("R4 other rnw", 3'd2, 32'h6);
        rchk("R4 addr kept", 3'd4, 32'hAAAA_0001);
        rchk("R4 be kept", 3'd5, 32'h0F);
        tout(2'd1, 32'hCCCC_0003, 8'h11, 4'h1, 3'd3, 1'b0, 1'b0, 1'b1);
        rchk("R4 locked rnw kept", 3'd2, 32'h6);
        rchk("R4 addr still kept", 3'd4, 32'hAAAA_0001);

        // R3 clear of locked owner
        wreg(3'd0, 32'h2);
        rchk("R3 detect", 3'd0, 32'h4);
        rchk("R3 lock", 3'd3, 32'h0);
        rchk("R3 rnw", 3'd2, 32'h4);

        // R5 record free again
        tout(2'd3, 32'hDDDD_0004, 8'h3C, 4'h5, 3'd4, 1'b0, 1'b0, 1'b1);
        rchk("R5 addr", 3'd4, 32'hDDDD_0004);
        rchk("R5 owner", 3'd1, 32'h8);
        rchk("R5 detect", 3'd0, 32'hC);

        // R6 read-only status
        wreg(3'd1, 32'hF); wreg(3'd2, 32'hF); wreg(3'd3, 32'hF);
        rchk("R6 owner", 3'd1, 32'h8);
        rchk("R6 rnw", 3'd2, 32'h4);
        rchk("R6 lock", 3'd3, 32'h0);

        // R3 partial clear
        wreg(3'd0, 32'h4);
        rchk("R3 partial detect", 3'd0, 32'h8);
        rchk("R3 partial rnw", 3'd2, 32'h0);

        // R7 test mode
        wreg(3'd4, 32'h1234_5678);
        rchk("R7 addr locked out", 3'd4, 32'hDDDD_0004);
        wreg(3'd7, 32'h5);
        rchk("R8 ctrl readback", 3'd7, 32'h5);
        wreg(3'd4, 32'h1234_5678);
        rchk("R7 addr written", 3'd4, 32'h1234_5678);
        wreg(3'd5, 32'hFFFF_FFFF);
        rchk("R7 be width", 3'd5, 32'hFF);
        wreg(3'd6, 32'hFFFF_FFFF);
        rchk("R7 size type width", 3'd6, 32'h7F);

        // R8/R9 interrupt disabled, then soft reset
        wreg(3'd7, 32'h0);
        rchk("R8 ctrl off", 3'd7, 32'h0);
        tout(2'd0, 32'h0000_0100, 8'h01, 4'h1, 3'd1, 1'b1, 1'b0, 1'b0);
        rchk("R9 capture without irq", 3'd0, 32'h9);
        wreg(3'd7, 32'h2);
        rchk("R8 ctrl after srst", 3'd7, 32'h1);
        rchk("R8 detect after srst", 3'd0, 32'h0);
        rchk("R8 addr after srst", 3'd4, 32'h0);
        rchk("R8 szt after srst", 3'd6, 32'h0);

        // R10 outside window
        @(negedge clk);
        reg_addr = BASE + AW'(8);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R10 no ack outside", {31'd0, reg_ack}, 32'd0);
        @(negedge clk);
        chk("R10 ack stays low", {31'd0, reg_ack}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule